// File: doc/BRIEF.md
# Configurable Overflow Timer with Prescaler

This block is an up-counting timer whose width is chosen at run time: either the full 16-bit count or only its low byte is used. Each step of the count comes from one of two sources. One is a per-cycle enable pulse from the core's instruction sequencer. The other is an edge on an external pin. Before it reaches the count register, the source can pass through a power-of-two prescaler, or skip it.

When the count wraps from its all-ones value back to zero, the block sets a sticky overflow flag. That flag stays high until the clear input is pulsed, and it drives the interrupt logic outside the block. Software can write the count register at any time and read it back. An 8-bit control word selects the mode. The external pin is not synchronous to the clock, so it goes through a two-flop synchronizer before its edges are detected.

Top module: `tmr_overflow_timer`

## Requirements
- R1: Control bit 0 (run) enables counting when 1. When it is 0, the count and the prescaler hold their values, apart from writes.
- R2: With control bit 1 at 0 (16-bit mode), each count step adds one to the 16-bit count. The step from 0xFFFF gives 0x0000 and sets the overflow flag in the same clock.
- R3: With control bit 1 at 1 (8-bit mode), the upper byte of the count reads zero, a write keeps only the low byte, and overflow happens on the step from 0x00FF to 0x0000. In 16-bit mode the step from 0x00FF to 0x0100 does not overflow.
- R4: Control bit 2 selects the source. At 0, each clock with the instruction-cycle enable high is one source tick. At 1, the enable is ignored and edges on the external pin are counted after a two-flop synchronizer.
- R5: Control bit 3 picks the pin edge. At 0, low-to-high transitions count. At 1, high-to-low transitions count.
- R6: Control bit 4 at 1 bypasses the prescaler, so each source tick is a count step. At 0, one count step happens per N source ticks, where control bits 7:5 set N = 2^(code+1) (code 0 gives 1:2, code 7 gives 1:256).
- R7: The overflow flag is 0 after reset. It stays 1 until the clear input is pulsed. If a clear and an overflow arrive in the same clock, the flag ends up set.
- R8: A write loads the count and takes priority over a step in the same clock. It also restarts the prescaler's internal division from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 8 | Control word (run, width, source, edge, bypass, ratio code) |
| icyc_en_i | input | 1 | Instruction-cycle enable pulse |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| cnt_wr_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | 16 | Count register write data |
| cnt_o | output | 16 | Current count value |
| flag_clr_i | input | 1 | Clears the overflow flag |
| flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench drives the count to both wrap points, 0xFFFF in 16-bit mode and 0x00FF in 8-bit mode. A design that judged overflow on the wrong width would either miss the flag or set it at 0x00FF while in 16-bit mode. It pulses the clear in the same clock as an overflow, which a design that let clear win would lose. It writes the count halfway through a prescale period and expects the next step only after a full period; a design that did not clear the prescaler would step too early. It also holds the pin at a fixed level under each edge setting, which shows whether a design counts the wrong polarity or lets the instruction enable leak into external mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W     = 16;
    localparam int NARROW_W  = 8;
    localparam int PS_CODE_W = 3;
    localparam int PCNT_W    = 2 ** PS_CODE_W;
    localparam int SYNC_N    = 2;

    typedef struct packed {
        logic [PS_CODE_W-1:0] ps_code;
        logic                 bypass;
        logic                 fall_edge;
        logic                 ext_src;
        logic                 narrow;
        logic                 run;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic             wrapped;
    } cnt_result_t;

    // Last prescaler count value of a period: 2^(code+1) - 1.
    function automatic logic [PCNT_W-1:0] ps_terminal(input logic [PS_CODE_W-1:0] code);
        logic [PCNT_W:0] span;
        logic [PCNT_W:0] last;
        span = {{(PCNT_W-1){1'b0}}, 2'b10} << code;
        last = span - {{PCNT_W{1'b0}}, 1'b1};
        return last[PCNT_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic tick_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= pin_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    assign level = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb begin
        if (fall_sel_i) tick_o = prev_q & ~level;
        else            tick_o = level & ~prev_q;
    end

    // R5: a tick always comes from a level change of the synchronized pin
    assert_tick_on_change_R5: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (level != prev_q));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 bypass_i,
    input  logic [PS_CODE_W-1:0] code_i,
    input  logic                 restart_i,
    output logic                 tick_o
);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] last;
    logic              at_last;

    assign last    = ps_terminal(code_i);
    assign at_last = (pcnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            pcnt_q <= '0;
        end else if (tick_i && !bypass_i) begin
            if (at_last) pcnt_q <= '0;
            else         pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_comb begin
        if (bypass_i) tick_o = tick_i;
        else          tick_o = tick_i & at_last;
    end

    // R8: a count write leaves the divider at zero
    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (pcnt_q == '0));

    // R1: without a source tick the divider holds
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> $stable(pcnt_q));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             narrow_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam int HI_W = CNT_W - NARROW_W;

    logic [CNT_W-1:0] cnt_q;
    cnt_result_t      inc;

    always_comb begin
        inc = '0;
        if (narrow_i) begin
            inc.value   = {{HI_W{1'b0}}, cnt_q[NARROW_W-1:0] + 1'b1};
            inc.wrapped = &cnt_q[NARROW_W-1:0];
        end else begin
            inc.value   = cnt_q + 1'b1;
            inc.wrapped = &cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            if (narrow_i) cnt_q <= {{HI_W{1'b0}}, wdata_i[NARROW_W-1:0]};
            else          cnt_q <= wdata_i;
        end else if (step_i) begin
            cnt_q <= inc.value;
        end else if (narrow_i) begin
            cnt_q <= {{HI_W{1'b0}}, cnt_q[NARROW_W-1:0]};
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = step_i & !wr_i & inc.wrapped;

    // R3: the upper byte reads zero in 8-bit mode
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        narrow_i |=> (cnt_q[CNT_W-1:NARROW_W] == '0));

    // R2: a 16-bit step adds exactly one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        (step_i && !wr_i && !narrow_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R8: a write lands in the count
    assert_write_loads_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !narrow_i) |=> (cnt_q == $past(wdata_i)));

endmodule

// File: rtl/tmr_overflow_timer.sv
module tmr_overflow_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              icyc_en_i,
    input  logic              ext_pin_i,
    input  logic              cnt_wr_i,
    input  logic [CNT_W-1:0]  cnt_wdata_i,
    output logic [CNT_W-1:0]  cnt_o,
    input  logic              flag_clr_i,
    output logic              flag_o
);

    tmr_ctrl_t ctrl;
    logic      ext_tick;
    logic      src_tick;
    logic      run_tick;
    logic      step;
    logic      wrap;
    logic      flag_q;

    assign ctrl = tmr_ctrl_t'(ctrl_i);

    tmr_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (ext_pin_i),
        .fall_sel_i (ctrl.fall_edge),
        .tick_o     (ext_tick)
    );

    assign src_tick = ctrl.ext_src ? ext_tick : icyc_en_i;
    assign run_tick = src_tick & ctrl.run;

    tmr_prescale u_ps (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (run_tick),
        .bypass_i  (ctrl.bypass),
        .code_i    (ctrl.ps_code),
        .restart_i (cnt_wr_i),
        .tick_o    (step)
    );

    tmr_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .narrow_i (ctrl.narrow),
        .wr_i     (cnt_wr_i),
        .wdata_i  (cnt_wdata_i),
        .cnt_o    (cnt_o),
        .wrap_o   (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (wrap)       flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R7: flag stays high until cleared
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr_i) |=> flag_q);

    // R1: a stopped 16-bit timer with no write keeps its count
    assert_run_freeze_R1: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_wr_i && !ctrl.narrow) |=> $stable(cnt_o));

    // R2: the flag rises only when the count has just wrapped to zero
    assert_flag_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> (cnt_o == '0));

endmodule

// File: tb/tmr_overflow_timer_bench.sv
module tmr_overflow_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ctrl = 8'h00;
    logic        icyc = 1'b1;
    logic        pin = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] cnt;
    logic        clr = 1'b0;
    logic        flag;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_overflow_timer u_tmr_overflow_timer (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .icyc_en_i(icyc), .ext_pin_i(pin),
        .cnt_wr_i(wr), .cnt_wdata_i(wdata), .cnt_o(cnt), .flag_clr_i(clr), .flag_o(flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bit order: code[7:5] bypass[4] fall[3] ext[2] narrow[1] run[0]
    task automatic set_ctrl(input bit run, input bit nar, input bit ext, input bit fall,
                            input bit byp, input logic [2:0] code);
        ctrl = {code, byp, fall, ext, nar, run};
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R7 reset flag", {15'h0, flag}, 16'h0);
        check("R1 reset count", cnt, 16'h0);
    endtask

    task automatic t_run();
        set_ctrl(1, 0, 0, 0, 1, 3'd0);
        load(16'd100);
        check("R8 load value", cnt, 16'd100);
        wait_n(20);
        check("R1 running", cnt, 16'd120);
        set_ctrl(0, 0, 0, 0, 1, 3'd0);
        wait_n(15);
        check("R1 stopped", cnt, 16'd120);
    endtask

    task automatic t_wrap16();
        set_ctrl(1, 0, 0, 0, 1, 3'd0);
        clear_flag();
        load(16'hFFFE);
        wait_n(1);
        check("R2 at FFFF", cnt, 16'hFFFF);
        check("R2 no flag yet", {15'h0, flag}, 16'h0);
        wait_n(1);
        check("R2 wrapped", cnt, 16'h0000);
        check("R2 flag set", {15'h0, flag}, 16'h1);
        wait_n(5);
        check("R7 flag held", {15'h0, flag}, 16'h1);
        clear_flag();
        check("R7 flag cleared", {15'h0, flag}, 16'h0);
    endtask

    task automatic t_wrap8();
        set_ctrl(1, 1, 0, 0, 1, 3'd0);
        clear_flag();
        load(16'h12FE);
        check("R3 write masked", cnt, 16'h00FE);
        wait_n(1);
        check("R3 at FF", cnt, 16'h00FF);
        check("R3 no flag yet", {15'h0, flag}, 16'h0);
        wait_n(1);
        check("R3 wrapped", cnt, 16'h0000);
        check("R3 flag set", {15'h0, flag}, 16'h1);
        set_ctrl(1, 0, 0, 0, 1, 3'd0);
        clear_flag();
        load(16'h00FF);
        wait_n(1);
        check("R3 wide carry", cnt, 16'h0100);
        check("R3 wide no flag", {15'h0, flag}, 16'h0);
    endtask

    task automatic t_set_clear();
        set_ctrl(1, 0, 0, 0, 1, 3'd0);
        clear_flag();
        load(16'hFFFF);
        clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check("R7 set beats clear", {15'h0, flag}, 16'h1);
        clear_flag();
    endtask

    task automatic t_icyc();
        set_ctrl(1, 0, 0, 0, 1, 3'd0);
        load(16'h0);
        for (int i = 0; i < 10; i++) begin
            icyc = (i % 2 == 0);
            @(negedge clk);
        end
        icyc = 1'b1;
        check("R4 internal enable", cnt, 16'd5);
    endtask

    task automatic t_ext();
        set_ctrl(1, 0, 1, 0, 1, 3'd0);
        load(16'h0);
        wait_n(6);
        check("R4 enable ignored", cnt, 16'd0);
        pin = 1'b1; wait_n(6);
        check("R5 rising counted", cnt, 16'd1);
        pin = 1'b0; wait_n(6);
        check("R5 falling skipped", cnt, 16'd1);
        set_ctrl(1, 0, 1, 1, 1, 3'd0);
        load(16'h0);
        pin = 1'b1; wait_n(6);
        check("R5 rising skipped", cnt, 16'd0);
        pin = 1'b0; wait_n(6);
        check("R5 falling counted", cnt, 16'd1);
    endtask

    task automatic t_prescale();
        set_ctrl(1, 0, 0, 0, 0, 3'd0);
        load(16'h0); wait_n(10);
        check("R6 ratio 2", cnt, 16'd5);
        set_ctrl(1, 0, 0, 0, 0, 3'd3);
        load(16'h0); wait_n(64);
        check("R6 ratio 16", cnt, 16'd4);
        set_ctrl(1, 0, 0, 0, 0, 3'd7);
        load(16'h0); wait_n(511);
        check("R6 ratio 256 early", cnt, 16'd1);
        wait_n(1);
        check("R6 ratio 256", cnt, 16'd2);
    endtask

    task automatic t_restart();
        set_ctrl(1, 0, 0, 0, 0, 3'd2);
        load(16'h0); wait_n(5);
        load(16'h40);
        check("R8 reload", cnt, 16'h40);
        wait_n(7);
        check("R8 divider restarted", cnt, 16'h40);
        wait_n(1);
        check("R8 full period", cnt, 16'h41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_run();
        t_wrap16();
        t_wrap8();
        t_set_clear();
        t_icyc();
        t_ext();
        t_prescale();
        t_restart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule